// File: doc/BRIEF.md
# Half-Bridge Adaptive Dead-Time Gate Controller

This block is the clocked decision logic in front of the two gate drivers of a synchronous buck half-bridge. It takes a pulse-width command, already reduced to two comparator bits, and turns it into a high-side gate command and a low-side gate command. Break-before-make is enforced with an adaptive dead time. After the high-side gate is released, the low-side gate waits until the switch node is seen below its threshold. If that never happens, it waits until the high-side gate voltage has stayed low for a fallback interval. A mid-level command held longer than a hold-off window parks both gates. An enable input, a low-side permit input, a supply-good flag and a boot-good flag can each force gates off or block them.

Every asynchronous input passes through a two-flop synchroniser. Each delay parameter `D_*` counts the total clock cycles from an input pin change to the gate change, and the two synchroniser stages are included in that count, so every `D_*` must be at least 2. The default values assume a 5 ns clock. The controller is a seven-state machine, and the present state is reported on `state_o` with these codes: OFF=0, HS_ON=1, HS_TURNOFF=2, WAIT_DEADTIME=3, LS_ON=4, LS_TURNOFF=5, TRISTATE_HOLD=6.

The transitions are as follows:
- OFF goes to HS_ON on a settled high command, or to LS_ON on a settled low command.
- HS_ON goes to HS_TURNOFF on a settled low command or on an expired third state.
- HS_TURNOFF goes to WAIT_DEADTIME on a low command, to TRISTATE_HOLD on an expired third state, and to OFF otherwise.
- WAIT_DEADTIME goes to LS_ON when dead time ends, to HS_ON on a settled high command, or to TRISTATE_HOLD.
- LS_ON goes to LS_TURNOFF on a settled high command, on an expired third state, or when the low-side permit drops.
- LS_TURNOFF goes to HS_ON, to TRISTATE_HOLD, to WAIT_DEADTIME on a low command, and to OFF otherwise.
- TRISTATE_HOLD goes to HS_ON or LS_ON after the exit delay.
- A halt condition forces OFF from any state.

Top module: `hb_gate_ctrl`

## Requirements
- R1: After reset, `state_o` is OFF (0), both gate outputs are 0 and `overlap_err_o` is 0.
- R2: The command level is decoded as follows: `pwm_hi_i`=1 means high, with priority; `pwm_lo_i`=1 with `pwm_hi_i`=0 means low; both 0 means the third state. From OFF or WAIT_DEADTIME, a high command with boot good and enable settled drives `hs_gate_o` to 1 (state HS_ON) exactly D_HS_ON cycles after the pin change.
- R3: In HS_ON, a low command drops `hs_gate_o` D_HS_OFF cycles after the pin change (HS_TURNOFF). The next cycle is WAIT_DEADTIME. `ls_gate_o` stays 0 there until `sw_low_i` rises, and then goes to 1 (LS_ON) D_LS_ON cycles after that rise.
- R4: In WAIT_DEADTIME with `sw_low_i` held at 0, `ls_gate_o` goes to 1 D_FALLBACK cycles after `hsg_low_i` rises.
- R5: In LS_ON, a high command drops `ls_gate_o` D_LS_OFF cycles after the pin change (LS_TURNOFF). `hs_gate_o` rises D_HS_ON cycles after the pin change, provided D_HS_ON > D_LS_OFF.
- R6: A third-state command that lasts less than D_HOLDOFF cycles leaves the gates unchanged. If the third state persists, the active gate drops D_HOLDOFF cycles after the pin change, and the next cycle is TRISTATE_HOLD (6).
- R7: From TRISTATE_HOLD, a high or low command turns on the matching gate D_TRI_EXIT cycles after the pin change.
- R8: `stage_en_i` held at 0 forces both gates off D_DISABLE cycles after its fall, and the state becomes OFF. A low pulse shorter than D_DISABLE - 1 cycles has no effect on the gates. After `stage_en_i` returns to 1, a gate can turn on no sooner than D_DISABLE cycles later.
- R9: When `ls_allow_i` is 0, the low-side gate stays 0 in the low phase (the state stays WAIT_DEADTIME). If `ls_allow_i` falls during LS_ON, `ls_gate_o` drops 2 cycles after the fall.
- R10: When `vcc_ok_i` is 0, both gates go to 0 (OFF) 2 cycles after its fall. After it returns to 1, a settled high command turns on `hs_gate_o` 2 cycles later.
- R11: While `boot_ok_i` is 0, `hs_gate_o` does not turn on. When `boot_ok_i` returns to 1, a settled high command turns on `hs_gate_o` 2 cycles later.
- R12: `hs_gate_o` and `ls_gate_o` are never both 1. The sticky flag `overlap_err_o` would record such an event, and it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_hi_i | input | 1 | Command comparator: level above the high threshold |
| pwm_lo_i | input | 1 | Command comparator: level below the low threshold |
| sw_low_i | input | 1 | Switch node below 1 V |
| hsg_low_i | input | 1 | High-side gate-source voltage below 1 V |
| vcc_ok_i | input | 1 | Logic supply above its undervoltage threshold |
| boot_ok_i | input | 1 | Boot supply above its undervoltage threshold |
| stage_en_i | input | 1 | Stage enable; 0 (or an undriven pin pulled low) disables |
| ls_allow_i | input | 1 | Low-side permit; 0 suppresses the low-side gate |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |
| state_o | output | 3 | Present controller state code |
| overlap_err_o | output | 1 | Sticky flag: both gate commands seen high |

## Verification
The embedded assertions check the following on every cycle: the gates never overlap, GH never rises straight out of a cycle in which GL was high, GH never rises without boot good, GL never rises without a low command, and a low supply flag or a low permit clears the gates one cycle later. Only the bench scenarios can show the exact delay counts, namely the switch-node path against the fallback path, the short third-state excursion that must change nothing, the disable pulse that is filtered out, and the exit from the parked state. The bench checks each of these at the cycle before and the cycle after the predicted edge.

// File: rtl/gdc_pkg.sv
package gdc_pkg;

    typedef enum logic [2:0] {
        ST_OFF           = 3'd0,
        ST_HS_ON         = 3'd1,
        ST_HS_TURNOFF    = 3'd2,
        ST_WAIT_DEADTIME = 3'd3,
        ST_LS_ON         = 3'd4,
        ST_LS_TURNOFF    = 3'd5,
        ST_TRISTATE_HOLD = 3'd6
    } gate_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gdc_sync.sv
module gdc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gdc_runlen.sv
// Counts how many earlier consecutive cycles lvl_i has been high (saturating).
module gdc_runlen #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_i,
    output logic [CW-1:0] run_o
);
    localparam logic [CW-1:0] RUN_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_o <= '0;
        else if (!lvl_i)           run_o <= '0;
        else if (run_o != RUN_MAX) run_o <= run_o + 1'b1;
    end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import gdc_pkg::*;
#(
    parameter int D_HS_ON     = 3,
    parameter int D_HS_OFF    = 4,
    parameter int D_LS_ON     = 4,
    parameter int D_FALLBACK  = 4,
    parameter int D_LS_OFF    = 2,
    parameter int D_HOLDOFF   = 48,
    parameter int D_TRI_EXIT  = 3,
    parameter int D_DISABLE   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_hi_i,
    input  logic       pwm_lo_i,
    input  logic       sw_low_i,
    input  logic       hsg_low_i,
    input  logic       vcc_ok_i,
    input  logic       boot_ok_i,
    input  logic       stage_en_i,
    input  logic       ls_allow_i,
    output logic       hs_gate_o,
    output logic       ls_gate_o,
    output logic [2:0] state_o,
    output logic       overlap_err_o
);
    localparam int SYNC_LAT   = 2;
    localparam int W_HS_ON    = D_HS_ON    - SYNC_LAT;
    localparam int W_HS_OFF   = D_HS_OFF   - SYNC_LAT;
    localparam int W_LS_ON    = D_LS_ON    - SYNC_LAT;
    localparam int W_FALLBACK = D_FALLBACK - SYNC_LAT;
    localparam int W_LS_OFF   = D_LS_OFF   - SYNC_LAT;
    localparam int W_HOLDOFF  = D_HOLDOFF  - SYNC_LAT;
    localparam int W_TRI_EXIT = D_TRI_EXIT - SYNC_LAT;
    localparam int W_DISABLE  = D_DISABLE  - SYNC_LAT;
    localparam int W_MAX = imax(imax(imax(W_HS_ON, W_HS_OFF), imax(W_LS_ON, W_FALLBACK)),
                                imax(imax(W_LS_OFF, W_HOLDOFF), imax(W_TRI_EXIT, W_DISABLE)));
    localparam int CW = $clog2(W_MAX + 2);

    // synchronised inputs
    localparam int NIN = 8;
    logic [NIN-1:0] raw_in, syn;
    assign raw_in = {pwm_hi_i, pwm_lo_i, sw_low_i, hsg_low_i,
                     vcc_ok_i, boot_ok_i, stage_en_i, ls_allow_i};

    gdc_sync #(.W(NIN), .STAGES(SYNC_LAT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn)
    );

    logic hi_s, lo_s, sw_s, hsg_s, vcc_s, boot_s, en_s, allow_s;
    assign {hi_s, lo_s, sw_s, hsg_s, vcc_s, boot_s, en_s, allow_s} = syn;

    logic hi_now, lo_now, mid_now;
    assign hi_now  = hi_s;
    assign lo_now  = lo_s & ~hi_s;
    assign mid_now = ~hi_s & ~lo_s;

    // run-length timers, one per qualified level
    localparam int L_HI = 0, L_LO = 1, L_MID = 2, L_SW = 3, L_HSG = 4, L_EN = 5, L_DIS = 6;
    localparam int NL = 7;
    logic [NL-1:0] lvl;
    logic [CW-1:0] run [NL];
    assign lvl = {~en_s, en_s, hsg_s, sw_s, mid_now, lo_now, hi_now};

    for (genvar g = 0; g < NL; g++) begin : g_run
        gdc_runlen #(.CW(CW)) u_run (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl_i (lvl[g]),
            .run_o (run[g])
        );
    end

    logic en_ok, halt, go_hs, go_ls, exit_hs, exit_ls, tri_held, hs_rel, ls_rel, dt_done;
    always_comb begin
        en_ok    = en_s && int'(run[L_EN]) >= W_DISABLE;
        halt     = !vcc_s || (!en_s && int'(run[L_DIS]) >= W_DISABLE);
        go_hs    = hi_now && boot_s && en_ok && int'(run[L_HI]) >= W_HS_ON;
        go_ls    = lo_now && allow_s && en_ok && int'(run[L_LO]) >= W_LS_ON;
        exit_hs  = hi_now && boot_s && en_ok && int'(run[L_HI]) >= W_TRI_EXIT;
        exit_ls  = lo_now && allow_s && en_ok && int'(run[L_LO]) >= W_TRI_EXIT;
        tri_held = mid_now && int'(run[L_MID]) >= W_HOLDOFF;
        hs_rel   = lo_now && int'(run[L_LO]) >= W_HS_OFF;
        ls_rel   = hi_now && int'(run[L_HI]) >= W_LS_OFF;
        dt_done  = lo_now && allow_s &&
                   ((sw_s && int'(run[L_SW]) >= W_LS_ON) ||
                    (hsg_s && int'(run[L_HSG]) >= W_FALLBACK));
    end

    // state machine
    gate_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (go_hs)      nxt = ST_HS_ON;
                else if (go_ls) nxt = ST_LS_ON;
            end
            ST_HS_ON: begin
                if (hs_rel || tri_held) nxt = ST_HS_TURNOFF;
            end
            ST_HS_TURNOFF: begin
                if (tri_held)    nxt = ST_TRISTATE_HOLD;
                else if (lo_now) nxt = ST_WAIT_DEADTIME;
                else             nxt = ST_OFF;
            end
            ST_WAIT_DEADTIME: begin
                if (go_hs)         nxt = ST_HS_ON;
                else if (tri_held) nxt = ST_TRISTATE_HOLD;
                else if (dt_done)  nxt = ST_LS_ON;
            end
            ST_LS_ON: begin
                if (ls_rel || tri_held || !allow_s) nxt = ST_LS_TURNOFF;
            end
            ST_LS_TURNOFF: begin
                if (go_hs)         nxt = ST_HS_ON;
                else if (tri_held) nxt = ST_TRISTATE_HOLD;
                else if (lo_now)   nxt = ST_WAIT_DEADTIME;
                else               nxt = ST_OFF;
            end
            ST_TRISTATE_HOLD: begin
                if (exit_hs)      nxt = ST_HS_ON;
                else if (exit_ls) nxt = ST_LS_ON;
            end
            default: nxt = ST_OFF;
        endcase
        if (halt) nxt = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        hs_gate_o = (state == ST_HS_ON);
        ls_gate_o = (state == ST_LS_ON);
        state_o   = state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      overlap_err_o <= 1'b0;
        else if (hs_gate_o && ls_gate_o) overlap_err_o <= 1'b1;
    end

    // assertions
    assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_o && ls_gate_o));
    assert_err_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !overlap_err_o);
    assert_break_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_o) |-> !$past(ls_gate_o));
    assert_boot_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_o) |-> $past(boot_s));
    assert_ls_needs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate_o) |-> $past(lo_now));
    assert_uvlo_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_s |=> (!hs_gate_o && !ls_gate_o));
    assert_skip_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !allow_s |=> !ls_gate_o);

endmodule

// File: tb/hb_gate_ctrl_bench.sv
module hb_gate_ctrl_bench;
    localparam time CLK_PERIOD = 5ns;
    localparam int  WATCHDOG   = 5000;

    localparam int D_HS_ON    = 3;
    localparam int D_HS_OFF   = 4;
    localparam int D_LS_ON    = 4;
    localparam int D_FALLBACK = 4;
    localparam int D_LS_OFF   = 2;
    localparam int D_HOLDOFF  = 48;
    localparam int D_TRI_EXIT = 3;
    localparam int D_DISABLE  = 4;

    localparam logic [2:0] S_OFF = 3'd0, S_HSON = 3'd1, S_HSOFF = 3'd2, S_WAIT = 3'd3,
                           S_LSON = 3'd4, S_LSOFF = 3'd5, S_TRI = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_hi = 1'b0, pwm_lo = 1'b0, sw_low = 1'b0, hsg_low = 1'b0;
    logic vcc_ok = 1'b1, boot_ok = 1'b1, stage_en = 1'b1, ls_allow = 1'b1;
    logic hs_gate, ls_gate, overlap_err;
    logic [2:0] state;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_gate_ctrl #(
        .D_HS_ON(D_HS_ON), .D_HS_OFF(D_HS_OFF), .D_LS_ON(D_LS_ON), .D_FALLBACK(D_FALLBACK),
        .D_LS_OFF(D_LS_OFF), .D_HOLDOFF(D_HOLDOFF), .D_TRI_EXIT(D_TRI_EXIT), .D_DISABLE(D_DISABLE)
    ) u_hb_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .pwm_hi_i(pwm_hi), .pwm_lo_i(pwm_lo),
        .sw_low_i(sw_low), .hsg_low_i(hsg_low), .vcc_ok_i(vcc_ok), .boot_ok_i(boot_ok),
        .stage_en_i(stage_en), .ls_allow_i(ls_allow),
        .hs_gate_o(hs_gate), .ls_gate_o(ls_gate), .state_o(state), .overlap_err_o(overlap_err)
    );

    typedef struct {
        int         cyc;
        logic       hs;
        logic       ls;
        logic [2:0] st;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // driver side: schedule an expected output at an offset from now
    task automatic expect_at(input int off, input logic hs, input logic ls,
                             input logic [2:0] st, input string tag);
        exp_t it;
        int   pos;
        it.cyc = cyc + off; it.hs = hs; it.ls = ls; it.st = st; it.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].cyc > it.cyc) begin pos = i; break; end
        end
        q.insert(pos, it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare at the scheduled cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if ((hs_gate && ls_gate) || overlap_err) begin
                fails++;
                $display("FAIL R12 cyc %0d: hs=%0b ls=%0b err=%0b expected no overlap, err=0",
                         cyc, hs_gate, ls_gate, overlap_err);
            end
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                checks++;
                if (q[0].cyc < cyc || hs_gate !== q[0].hs || ls_gate !== q[0].ls
                    || state !== q[0].st) begin
                    fails++;
                    $display("FAIL %s cyc %0d: hs=%0b ls=%0b st=%0d expected hs=%0b ls=%0b st=%0d",
                             q[0].tag, cyc, hs_gate, ls_gate, state, q[0].hs, q[0].ls, q[0].st);
                end
                void'(q.pop_front());
            end
        end
    end

    task automatic finish_up;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R12: %0d scheduled checks not reached, expected 0", q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog: cycle %0d reached, expected run to complete", cyc);
            finish_up();
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        // R1: reset state
        expect_at(1, 0, 0, S_OFF, "R1");
        tick(20);

        // R2: high command from OFF
        pwm_hi = 1'b1;
        expect_at(D_HS_ON,     0, 0, S_OFF,  "R2");
        expect_at(D_HS_ON + 1, 1, 0, S_HSON, "R2");
        tick(10);

        // R3: low command, wait for switch node flag
        pwm_hi = 1'b0; pwm_lo = 1'b1;
        expect_at(D_HS_OFF,     1, 0, S_HSON,  "R3");
        expect_at(D_HS_OFF + 1, 0, 0, S_HSOFF, "R3");
        expect_at(D_HS_OFF + 2, 0, 0, S_WAIT,  "R3");
        tick(16);
        expect_at(1, 0, 0, S_WAIT, "R3");
        sw_low = 1'b1;
        expect_at(D_LS_ON,     0, 0, S_WAIT, "R3");
        expect_at(D_LS_ON + 1, 0, 1, S_LSON, "R3");
        tick(10);

        // R5: high command from LS_ON
        pwm_lo = 1'b0; pwm_hi = 1'b1; sw_low = 1'b0; hsg_low = 1'b0;
        expect_at(D_LS_OFF,     0, 1, S_LSON,  "R5");
        expect_at(D_LS_OFF + 1, 0, 0, S_LSOFF, "R5");
        expect_at(D_HS_ON,      0, 0, S_LSOFF, "R5");
        expect_at(D_HS_ON + 1,  1, 0, S_HSON,  "R5");
        tick(10);

        // R4: fallback path via high-side gate flag
        pwm_hi = 1'b0; pwm_lo = 1'b1;
        expect_at(D_HS_OFF + 2, 0, 0, S_WAIT, "R4");
        tick(8);
        hsg_low = 1'b1;
        expect_at(D_FALLBACK,     0, 0, S_WAIT, "R4");
        expect_at(D_FALLBACK + 1, 0, 1, S_LSON, "R4");
        tick(10);

        // R9: low-side permit drops during LS_ON, then holds GL off
        ls_allow = 1'b0;
        expect_at(2, 0, 1, S_LSON,  "R9");
        expect_at(3, 0, 0, S_LSOFF, "R9");
        expect_at(4, 0, 0, S_WAIT,  "R9");
        tick(10);
        expect_at(2, 0, 0, S_WAIT, "R9");
        tick(4);
        ls_allow = 1'b1; pwm_lo = 1'b0; pwm_hi = 1'b1; hsg_low = 1'b0;
        expect_at(D_HS_ON,     0, 0, S_WAIT, "R2");
        expect_at(D_HS_ON + 1, 1, 0, S_HSON, "R2");
        tick(10);

        // R6: short third-state excursion has no effect
        pwm_hi = 1'b0;
        expect_at(5,  1, 0, S_HSON, "R6");
        expect_at(15, 1, 0, S_HSON, "R6");
        tick(20);
        pwm_hi = 1'b1;
        expect_at(5, 1, 0, S_HSON, "R6");
        tick(10);

        // R6: held third state parks the stage
        pwm_hi = 1'b0;
        expect_at(D_HOLDOFF,     1, 0, S_HSON,  "R6");
        expect_at(D_HOLDOFF + 1, 0, 0, S_HSOFF, "R6");
        expect_at(D_HOLDOFF + 2, 0, 0, S_TRI,   "R6");
        tick(60);

        // R7: exit to low side
        pwm_lo = 1'b1;
        expect_at(D_TRI_EXIT,     0, 0, S_TRI,  "R7");
        expect_at(D_TRI_EXIT + 1, 0, 1, S_LSON, "R7");
        tick(10);
        pwm_lo = 1'b0; pwm_hi = 1'b1;
        expect_at(D_LS_OFF + 1, 0, 0, S_LSOFF, "R5");
        expect_at(D_HS_ON + 1,  1, 0, S_HSON,  "R5");
        tick(10);
        pwm_hi = 1'b0;
        expect_at(D_HOLDOFF + 2, 0, 0, S_TRI, "R6");
        tick(60);
        // R7: exit to high side
        pwm_hi = 1'b1;
        expect_at(D_TRI_EXIT,     0, 0, S_TRI,  "R7");
        expect_at(D_TRI_EXIT + 1, 1, 0, S_HSON, "R7");
        tick(10);

        // R8: short disable pulse filtered
        stage_en = 1'b0;
        expect_at(3, 1, 0, S_HSON, "R8");
        expect_at(5, 1, 0, S_HSON, "R8");
        expect_at(7, 1, 0, S_HSON, "R8");
        tick(2);
        stage_en = 1'b1;
        tick(10);
        // R8: held disable
        stage_en = 1'b0;
        expect_at(D_DISABLE,     1, 0, S_HSON, "R8");
        expect_at(D_DISABLE + 1, 0, 0, S_OFF,  "R8");
        tick(12);
        expect_at(1, 0, 0, S_OFF, "R8");
        tick(2);
        stage_en = 1'b1;
        expect_at(D_DISABLE,     0, 0, S_OFF,  "R8");
        expect_at(D_DISABLE + 1, 1, 0, S_HSON, "R8");
        tick(10);

        // R10: supply undervoltage
        vcc_ok = 1'b0;
        expect_at(2, 1, 0, S_HSON, "R10");
        expect_at(3, 0, 0, S_OFF,  "R10");
        tick(10);
        expect_at(1, 0, 0, S_OFF, "R10");
        tick(2);
        vcc_ok = 1'b1;
        expect_at(2, 0, 0, S_OFF,  "R10");
        expect_at(3, 1, 0, S_HSON, "R10");
        tick(10);

        // R11: boot undervoltage blocks GH
        pwm_hi = 1'b0; pwm_lo = 1'b1;
        expect_at(D_HS_OFF + 2, 0, 0, S_WAIT, "R11");
        tick(8);
        sw_low = 1'b1;
        expect_at(D_LS_ON + 1, 0, 1, S_LSON, "R11");
        tick(8);
        pwm_lo = 1'b0; pwm_hi = 1'b1; sw_low = 1'b0; boot_ok = 1'b0;
        expect_at(3,  0, 0, S_LSOFF, "R11");
        expect_at(4,  0, 0, S_OFF,   "R11");
        expect_at(10, 0, 0, S_OFF,   "R11");
        expect_at(20, 0, 0, S_OFF,   "R11");
        tick(24);
        boot_ok = 1'b1;
        expect_at(2, 0, 0, S_OFF,  "R11");
        expect_at(3, 1, 0, S_HSON, "R11");
        tick(10);

        finish_up();
    end
endmodule